// File: doc/BRIEF.md
# Multi-Channel Transmit Input Capture

This block accepts transmit words for eight channels, each presented on its own parallel input and timed by a transmit clock. Every channel word is sampled twice per transmit clock period, once at the rising edge and once at the falling edge. The two samples form a pair. The pair is carried across a small per-channel phase-compensation FIFO into the reference clock domain. Each transmit clock has the same frequency as the reference clock but an arbitrary phase, so the FIFO only absorbs phase and does not adapt rates. On the reference side one pair per channel comes out every cycle.

Clocking is chosen by a strap input OR-ed with a configuration bit. When both are low, one clock (`txClk[0]`) times every channel. When either is high, four clocks are used and each one times a pair of neighbouring channels. A second pair of strap inputs, which a configuration override can replace, selects the parallel interface mode. Two of the four codes are reserved. While a reserved code is active, the block reports an error and keeps every output idle. A configuration input selects whether a word is nine bits (eight data bits plus a control flag) or ten raw bits.

Top module: `txcap_top`

## Requirements
- R1: `independent` is 1 exactly when `clkSelStrap` or `cfgClkIndep` is 1 (registered once). It is 0 only when both are 0, and 0 is the value after reset.
- R2: In shared mode every channel is timed by `txClk[0]`. Stopping any other transmit clock has no effect on `rxValid` or `fifoErr`.
- R3: In split mode `txClk[g]` times channels 2g and 2g+1. Stopping `txClk[1]` starves only channels 2 and 3.
- R4: Each output pair holds the rising-edge sample in bits [9:0] and the following falling-edge sample in bits [19:10]. Successive pairs continue the input sequence with no gap or reordering.
- R5: With `cfgRawWord`=0, bits [7:0] carry data, bit 8 carries the control flag and bit 9 of every output word is forced to 0. With `cfgRawWord`=1 all ten bits pass unchanged.
- R6: The effective mode code {bit1,bit0} is `cfgModeReg` when `cfgModeOvr`=1 and `modeStrap` otherwise. Code 00 is multiplexed mode and 10 is nibble mode (`nibbleMode`=1). Codes 01 and 11 set `modeError`=1 and keep all `rxValid` at 0.
- R7: Reset, a change of `independent`, or a reserved mode code empties all FIFOs. The empty state is held for 4 reference cycles, and `rxValid` is 0 from the second cycle after the clock-mode change. A channel resumes only once its FIFO holds at least 2 pairs.
- R8: An underflow on a channel sets `fifoErr[c]`. The flag stays set until `errClear[c]` is pulsed, and a new error event wins over a clear.
- R9: A write into a full FIFO is dropped and sets `fifoErr[c]`.
- R10: When `rxValid[c]`=0, the 20 bits of channel c on `rxPairs` are 0. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock, read side of all FIFOs |
| rstN | input | 1 | Asynchronous active-low reset |
| txClk | input | 4 | Transmit clocks; bit g serves channels 2g and 2g+1 in split mode |
| clkSelStrap | input | 1 | Strap requesting split clocking |
| cfgClkIndep | input | 1 | Configuration bit requesting split clocking |
| modeStrap | input | 2 | Interface mode strap code |
| cfgModeOvr | input | 1 | Use `cfgModeReg` in place of the strap code |
| cfgModeReg | input | 2 | Configured interface mode code |
| cfgRawWord | input | 1 | 1: ten raw bits; 0: data byte plus control flag |
| txWords | input | 80 | Channel words, channel c at bits [10c+9:10c] |
| errClear | input | 8 | Per-channel clear of the sticky error flag |
| rxPairs | output | 160 | Channel c pair at bits [20c+19:20c] |
| rxValid | output | 8 | Pair on `rxPairs` is valid this cycle |
| fifoErr | output | 8 | Sticky per-channel overflow/underflow flag |
| modeError | output | 1 | Reserved interface mode code active |
| nibbleMode | output | 1 | Nibble interface mode decoded |
| independent | output | 1 | Split clocking active |

## Verification
A wrong pointer or a lost edge in a channel shows at the ports within a few reference cycles. It appears as a break in the running sequence carried by the data words: a pair that repeats, skips or swaps its halves. A wrong clock-to-channel mapping shows only when one clock is stopped, so the bench stops clocks selectively. A starved pair of channels then loses `rxValid` and raises `fifoErr` within a handful of cycles, while the other channels keep streaming. A faster transmit clock raises the overflow flag once a few extra pairs have accumulated.

// File: rtl/txcap_pkg.sv
package txcap_pkg;

  // strobes from the control module to the datapath
  typedef struct packed {
    logic flush;    // empty all FIFOs, hold write side in reset
    logic indep;    // split clocking active
    logic rawWord;  // pass ten raw bits
  } txcap_ctl_t;

endpackage

// File: rtl/txcap_ctrl.sv
module txcap_ctrl
  import txcap_pkg::*;
#(
  parameter int FLUSH_CYC = 4
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       clkSelStrap,
  input  logic       cfgClkIndep,
  input  logic [1:0] modeStrap,
  input  logic       cfgModeOvr,
  input  logic [1:0] cfgModeReg,
  input  logic       cfgRawWord,
  output txcap_ctl_t ctl,
  output logic       modeError,
  output logic       nibbleMode
);

  localparam int CW = $clog2(FLUSH_CYC + 1);

  logic          indepQ;
  logic          indepPrev;
  logic [1:0]    codeQ;
  logic          rawQ;
  logic [CW-1:0] flushCnt;
  logic          restart;

  assign restart = (indepQ != indepPrev) | codeQ[0];

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      indepQ    <= 1'b0;
      indepPrev <= 1'b0;
      codeQ     <= 2'b00;
      rawQ      <= 1'b0;
      flushCnt  <= CW'(FLUSH_CYC);
    end else begin
      indepQ    <= clkSelStrap | cfgClkIndep;
      indepPrev <= indepQ;
      codeQ     <= cfgModeOvr ? cfgModeReg : modeStrap;
      rawQ      <= cfgRawWord;
      if (restart)
        flushCnt <= CW'(FLUSH_CYC);
      else if (flushCnt != '0)
        flushCnt <= flushCnt - CW'(1);
    end
  end

  assign ctl.flush   = (flushCnt != '0);
  assign ctl.indep   = indepQ;
  assign ctl.rawWord = rawQ;
  assign modeError   = codeQ[0];
  assign nibbleMode  = (codeQ == 2'b10);

  AST_INDEP_OR: assert property (@(posedge refClk) disable iff (!rstN)
    $past(rstN) |-> ctl.indep == $past(clkSelStrap | cfgClkIndep)); // R1

  AST_RESERVED_FLAG: assert property (@(posedge refClk) disable iff (!rstN)
    $past(rstN) |-> modeError == $past(cfgModeOvr ? cfgModeReg[0] : modeStrap[0])); // R6

  AST_ERR_FLUSHES: assert property (@(posedge refClk) disable iff (!rstN)
    modeError |=> ctl.flush); // R6

endmodule

// File: rtl/txcap_chfifo.sv
module txcap_chfifo
  import txcap_pkg::*;
#(
  parameter int WW    = 10,
  parameter int DEPTH = 8,
  parameter int PRIME = 2
) (
  input  logic          refClk,
  input  logic          rstN,
  input  logic          wClk,
  input  txcap_ctl_t    ctl,
  input  logic [WW-1:0] din,
  input  logic          errClear,
  output logic [2*WW-1:0] outPair,
  output logic          outValid,
  output logic          errFlag
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int EW = 2 * WW;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // ---------------- write side (transmit clock) ----------------
  logic          wrRst;
  logic [WW-1:0] shaped;
  logic [WW-1:0] posWord;
  logic [PW-1:0] wBin, wGray;
  logic [PW-1:0] rq1, rq2;
  logic          full, wEn;
  logic          ovfTgl;
  logic [EW-1:0] mem [DEPTH];

  assign wrRst  = ctl.flush | ~rstN;
  assign shaped = ctl.rawWord ? din : {1'b0, din[WW-2:0]};
  assign full   = (wGray == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
  assign wEn    = ~full & ~wrRst;

  always_ff @(posedge wClk or posedge wrRst) begin
    if (wrRst) posWord <= '0;
    else       posWord <= shaped;
  end

  always_ff @(negedge wClk or posedge wrRst) begin
    if (wrRst) begin
      wBin  <= '0;
      wGray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      rq1 <= rGray;
      rq2 <= rq1;
      if (!full) begin
        wBin  <= wBin + PW'(1);
        wGray <= b2g(wBin + PW'(1));
      end
    end
  end

  always_ff @(negedge wClk) begin
    if (wEn) mem[wBin[AW-1:0]] <= {shaped, posWord};
  end

  always_ff @(negedge wClk or negedge rstN) begin
    if (!rstN)               ovfTgl <= 1'b0;
    else if (full && !wrRst) ovfTgl <= ~ovfTgl;
  end

  // ---------------- read side (reference clock) ----------------
  logic [PW-1:0] rBin, rGray;
  logic [PW-1:0] wq1, wq2;
  logic [PW-1:0] occ;
  logic          reading, empty, pop, underflow;
  logic          os1, os2, os3, ovfEvt;

  assign occ       = g2b(wq2) - rBin;
  assign empty     = (occ == '0);
  assign pop       = reading & ~empty & ~ctl.flush;
  assign underflow = reading & empty & ~ctl.flush;
  assign ovfEvt    = os2 ^ os3;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      wq1 <= '0; wq2 <= '0; rBin <= '0; rGray <= '0;
      reading <= 1'b0; outValid <= 1'b0; outPair <= '0;
    end else if (ctl.flush) begin
      wq1 <= '0; wq2 <= '0; rBin <= '0; rGray <= '0;
      reading <= 1'b0; outValid <= 1'b0; outPair <= '0;
    end else begin
      wq1 <= wGray;
      wq2 <= wq1;
      if (!reading && occ >= PW'(PRIME)) reading <= 1'b1;
      else if (reading && empty)         reading <= 1'b0;
      outValid <= pop;
      outPair  <= pop ? mem[rBin[AW-1:0]] : '0;
      if (pop) begin
        rBin  <= rBin + PW'(1);
        rGray <= b2g(rBin + PW'(1));
      end
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      os1 <= 1'b0; os2 <= 1'b0; os3 <= 1'b0; errFlag <= 1'b0;
    end else begin
      os1 <= ovfTgl;
      os2 <= os1;
      os3 <= os2;
      if (underflow || ovfEvt) errFlag <= 1'b1;
      else if (errClear)       errFlag <= 1'b0;
    end
  end

  AST_FLUSH_QUIETS: assert property (@(posedge refClk) disable iff (!rstN)
    ctl.flush |=> !outValid); // R7

  AST_START_PRIMED: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(reading) |-> $past(occ) >= PW'(PRIME)); // R7

  AST_STICKY_HOLD: assert property (@(posedge refClk) disable iff (!rstN)
    errFlag && !errClear |=> errFlag); // R8

  AST_GRAY_ONE_STEP: assert property (@(negedge wClk) disable iff (wrRst)
    $countones(wGray ^ $past(wGray)) <= 1); // R4

endmodule

// File: rtl/txcap_datapath.sv
module txcap_datapath
  import txcap_pkg::*;
#(
  parameter int NGRP  = 4,
  parameter int WW    = 10,
  parameter int DEPTH = 8,
  parameter int PRIME = 2
) (
  input  logic                     refClk,
  input  logic                     rstN,
  input  logic [NGRP-1:0]          txClk,
  input  txcap_ctl_t               ctl,
  input  logic [2*NGRP*WW-1:0]     txWords,
  input  logic [2*NGRP-1:0]        errClear,
  output logic [2*NGRP*2*WW-1:0]   rxPairs,
  output logic [2*NGRP-1:0]        rxValid,
  output logic [2*NGRP-1:0]        fifoErr
);

  localparam int CPG = 2;
  localparam int NCH = CPG * NGRP;
  localparam int EW  = 2 * WW;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int G = c / CPG;
    logic chClk;

    assign chClk = ctl.indep ? txClk[G] : txClk[0];

    txcap_chfifo #(.WW(WW), .DEPTH(DEPTH), .PRIME(PRIME)) u_fifo (
      .refClk   (refClk),
      .rstN     (rstN),
      .wClk     (chClk),
      .ctl      (ctl),
      .din      (txWords[c*WW +: WW]),
      .errClear (errClear[c]),
      .outPair  (rxPairs[c*EW +: EW]),
      .outValid (rxValid[c]),
      .errFlag  (fifoErr[c])
    );
  end

endmodule

// File: rtl/txcap_top.sv
module txcap_top
  import txcap_pkg::*;
#(
  parameter int NGRP      = 4,
  parameter int WW        = 10,
  parameter int DEPTH     = 8,
  parameter int PRIME     = 2,
  parameter int FLUSH_CYC = 4
) (
  input  logic                   refClk,
  input  logic                   rstN,
  input  logic [NGRP-1:0]        txClk,
  input  logic                   clkSelStrap,
  input  logic                   cfgClkIndep,
  input  logic [1:0]             modeStrap,
  input  logic                   cfgModeOvr,
  input  logic [1:0]             cfgModeReg,
  input  logic                   cfgRawWord,
  input  logic [2*NGRP*WW-1:0]   txWords,
  input  logic [2*NGRP-1:0]      errClear,
  output logic [2*NGRP*2*WW-1:0] rxPairs,
  output logic [2*NGRP-1:0]      rxValid,
  output logic [2*NGRP-1:0]      fifoErr,
  output logic                   modeError,
  output logic                   nibbleMode,
  output logic                   independent
);

  txcap_ctl_t ctl;

  txcap_ctrl #(.FLUSH_CYC(FLUSH_CYC)) u_ctrl (
    .refClk      (refClk),
    .rstN        (rstN),
    .clkSelStrap (clkSelStrap),
    .cfgClkIndep (cfgClkIndep),
    .modeStrap   (modeStrap),
    .cfgModeOvr  (cfgModeOvr),
    .cfgModeReg  (cfgModeReg),
    .cfgRawWord  (cfgRawWord),
    .ctl         (ctl),
    .modeError   (modeError),
    .nibbleMode  (nibbleMode)
  );

  txcap_datapath #(.NGRP(NGRP), .WW(WW), .DEPTH(DEPTH), .PRIME(PRIME)) u_dp (
    .refClk   (refClk),
    .rstN     (rstN),
    .txClk    (txClk),
    .ctl      (ctl),
    .txWords  (txWords),
    .errClear (errClear),
    .rxPairs  (rxPairs),
    .rxValid  (rxValid),
    .fifoErr  (fifoErr)
  );

  assign independent = ctl.indep;

  AST_MODE_ERR_IDLE: assert property (@(posedge refClk) disable iff (!rstN)
    modeError && $past(modeError) |=> rxValid == '0); // R6

endmodule

// File: tb/tb_txcap_top.sv
module tb_txcap_top;
  localparam int CLK_PERIOD = 10;
  localparam int NGRP = 4;
  localparam int NCH  = 8;
  localparam int WW   = 10;

  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic [NGRP-1:0] rawClk = '0;
  logic [NGRP-1:0] clkEn = '1;
  logic [NGRP-1:0] gclk;
  int halfH = CLK_PERIOD / 2;

  logic clkSelStrap = 0, cfgClkIndep = 0, cfgModeOvr = 0, cfgRawWord = 0;
  logic [1:0] modeStrap = 0, cfgModeReg = 0;
  logic [NCH*WW-1:0]   txWords;
  logic [NCH-1:0]      errClear = '0;
  logic [NCH*2*WW-1:0] rxPairs;
  logic [NCH-1:0]      rxValid, fifoErr;
  logic modeError, nibbleMode, independent;

  int nChecks = 0, nFails = 0;
  bit sbEn = 0;
  bit done = 0;
  logic [7:0] prevHi [NCH];
  bit havePrev [NCH];

  txcap_top dut (
    .refClk(refClk), .rstN(rstN), .txClk(gclk),
    .clkSelStrap(clkSelStrap), .cfgClkIndep(cfgClkIndep),
    .modeStrap(modeStrap), .cfgModeOvr(cfgModeOvr), .cfgModeReg(cfgModeReg),
    .cfgRawWord(cfgRawWord), .txWords(txWords), .errClear(errClear),
    .rxPairs(rxPairs), .rxValid(rxValid), .fifoErr(fifoErr),
    .modeError(modeError), .nibbleMode(nibbleMode), .independent(independent)
  );

  always #(CLK_PERIOD/2) refClk = ~refClk;

  for (genvar g = 0; g < NGRP; g++) begin : g_clk
    initial begin
      #(1 + g);
      forever begin
        if (g == NGRP - 1) #(halfH); else #(CLK_PERIOD/2);
        rawClk[g] = ~rawClk[g];
      end
    end
    assign gclk[g] = rawClk[g] & clkEn[g];

    // data source: a running sequence advanced on each edge of the governing clock
    logic gov;
    logic [7:0] sq0 = 8'(g * 40);
    logic [7:0] sq1 = 8'(g * 40 + 100);
    assign gov = (clkSelStrap | cfgClkIndep) ? gclk[g] : gclk[0];
    always @(gov) begin
      #1;
      sq0 = sq0 + 8'd1;
      sq1 = sq1 + 8'd1;
    end
    assign txWords[(2*g)*WW +: WW]   = {1'b1, ~sq0[0], sq0};
    assign txWords[(2*g+1)*WW +: WW] = {1'b1, ~sq1[0], sq1};
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard on the stream: pair order and word format
  always @(negedge refClk) begin
    for (int c = 0; c < NCH; c++) begin
      if (rstN && sbEn && rxValid[c]) begin
        logic [9:0] lo, hi;
        lo = rxPairs[c*20 +: 10];
        hi = rxPairs[c*20+10 +: 10];
        check(hi[7:0] == lo[7:0] + 8'd1, "R4 pair order", 32'(hi), 32'(lo));
        if (havePrev[c])
          check(lo[7:0] == prevHi[c] + 8'd1, "R4 pair continuity", 32'(lo), 32'(prevHi[c] + 8'd1));
        check(lo[9] == cfgRawWord && hi[9] == cfgRawWord && lo[8] == ~lo[0] && hi[8] == ~hi[0],
              "R5 word format", {22'd0, hi}, {31'd0, cfgRawWord});
        prevHi[c] = hi[7:0];
        havePrev[c] = 1;
      end else begin
        havePrev[c] = 0;
      end
    end
  end

  // fields: strap cfgInd modeStrap[2] ovr modeReg[2] raw | expInd expErr expNib
  localparam logic [10:0] VEC [9] = '{
    11'b0_0_00_0_00_0_0_0_0,
    11'b1_0_00_0_00_1_1_0_0,
    11'b0_1_10_0_00_0_1_0_1,
    11'b1_1_10_0_00_1_1_0_1,
    11'b0_0_01_0_00_0_0_1_0,
    11'b0_0_01_1_10_0_0_0_1,
    11'b0_0_00_1_11_0_0_1_0,
    11'b0_0_11_0_00_0_0_1_0,
    11'b0_0_00_0_00_1_0_0_0
  };

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // reset state
    repeat (5) @(negedge refClk);
    check(rxValid == '0, "R10 reset valid", 32'(rxValid), 0);
    check(rxPairs == '0, "R10 reset data", 32'(rxPairs[31:0]), 0);
    check(fifoErr == '0, "R8 reset flags", 32'(fifoErr), 0);
    check(independent == 0, "R1 reset clock mode", 32'(independent), 0);
    rstN = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge refClk);
      check(rxValid == '0, "R7 hold after reset", 32'(rxValid), 0);
    end

    // table walk
    for (int i = 0; i < 9; i++) begin
      sbEn = 0;
      {clkSelStrap, cfgClkIndep, modeStrap, cfgModeOvr, cfgModeReg, cfgRawWord} = VEC[i][10:3];
      repeat (40) @(negedge refClk);
      errClear = '1; @(negedge refClk); errClear = '0;
      sbEn = 1;
      repeat (40) @(negedge refClk);
      check(independent == VEC[i][2], "R1 clock mode", 32'(independent), 32'(VEC[i][2]));
      check(modeError == VEC[i][1], "R6 mode error", 32'(modeError), 32'(VEC[i][1]));
      check(nibbleMode == VEC[i][0], "R6 nibble decode", 32'(nibbleMode), 32'(VEC[i][0]));
      check(rxValid == (VEC[i][1] ? 8'h00 : 8'hFF), "R6 valid per mode", 32'(rxValid), VEC[i][1] ? 0 : 32'hFF);
      if (VEC[i][1]) check(rxPairs == '0, "R10 idle data", 32'(rxPairs[31:0]), 0);
      check(fifoErr == '0, "R8 no spurious error", 32'(fifoErr), 0);
    end

    // shared clocking: stopping txClk[1] changes nothing
    clkEn[1] = 0;
    repeat (60) @(negedge refClk);
    check(rxValid == 8'hFF, "R2 shared clock valid", 32'(rxValid), 32'hFF);
    check(fifoErr == 8'h00, "R2 shared clock flags", 32'(fifoErr), 0);
    clkEn[1] = 1;

    // clock-mode change flushes
    sbEn = 0;
    cfgClkIndep = 1;
    repeat (3) @(negedge refClk);
    check(rxValid == 8'h00, "R7 flush on clock-mode change", 32'(rxValid), 0);
    repeat (40) @(negedge refClk);
    sbEn = 1;
    repeat (20) @(negedge refClk);
    check(rxValid == 8'hFF, "R7 resume after flush", 32'(rxValid), 32'hFF);
    check(fifoErr == 8'h00, "R7 clean flush", 32'(fifoErr), 0);

    // split clocking: stopping txClk[1] starves channels 2 and 3
    sbEn = 0;
    clkEn[1] = 0;
    repeat (30) @(negedge refClk);
    check(fifoErr == 8'h0C, "R3 starved pair flagged", 32'(fifoErr), 32'h0C);
    check(rxValid == 8'hF3, "R3 starved pair idle", 32'(rxValid), 32'hF3);
    clkEn[1] = 1;
    repeat (30) @(negedge refClk);
    check(fifoErr == 8'h0C, "R8 flag sticky", 32'(fifoErr), 32'h0C);
    check(rxValid == 8'hFF, "R3 pair resumes", 32'(rxValid), 32'hFF);
    errClear = 8'h0C; @(negedge refClk); errClear = '0;
    @(negedge refClk);
    check(fifoErr == 8'h00, "R8 flag cleared", 32'(fifoErr), 0);

    // faster txClk[3] overflows channels 6 and 7
    halfH = CLK_PERIOD / 2 - 1;
    repeat (150) @(negedge refClk);
    check(fifoErr[7:6] == 2'b11, "R9 overflow flagged", 32'(fifoErr), 32'hC0);
    check(fifoErr[5:0] == 6'd0, "R9 other channels clean", 32'(fifoErr), 32'hC0);
    halfH = CLK_PERIOD / 2;
    cfgClkIndep = 0;
    repeat (40) @(negedge refClk);
    errClear = '1; @(negedge refClk); errClear = '0;
    sbEn = 1;
    repeat (40) @(negedge refClk);
    check(fifoErr == 8'h00, "R8 clear after recovery", 32'(fifoErr), 0);
    check(rxValid == 8'hFF, "R2 shared clock resumes", 32'(rxValid), 32'hFF);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule